// File: doc/BRIEF.md
# Frame Rate Decimator with Field Parity Filter

This block sits in a camera capture path, in front of the memory writer. At every start-of-frame pulse it decides whether the frame or field that follows is forwarded or discarded. The decision combines two rules. A field-parity filter can keep only even fields, only odd fields, or both. A decimation counter then keeps only the first of each group of eligible frames, where the group length is set by a 4-bit code.

Pixels arrive on a valid/ready stream and leave on a valid/ready stream. During an accepted frame the block forwards the stream unchanged and `out_ready` reaches the source as `in_ready`, so back-pressure passes straight through. During a rejected frame `in_ready` is held high and every beat is consumed and discarded, so back-pressure from downstream has no effect. A level output reports whether the current frame is being kept. The decimation code and the field select are plain control inputs. Each is sampled only on the start-of-frame cycle.

Top module: `frame_decim_filter`

## Requirements
- R1: From reset until the first start-of-frame pulse, no frame is accepted: `frame_accept_o` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: The accept decision is made on the cycle where `sof_i` is 1 and is visible from the next cycle. It then holds until the next `sof_i` pulse. Changing the code or the field select in the middle of a frame has no effect until that next pulse.
- R3: Decimation codes 0 and 1 both mean no decimation: every frame that passes the field filter is accepted.
- R4: A decimation code N from 2 to 15 accepts the first of every N+1 eligible frames. For example, N=2 accepts eligible frames 0, 3, 6 and N=15 accepts eligible frames 0 and 16.
- R5: If the code sampled at a start-of-frame differs from the code sampled at the previous start-of-frame, the group restarts, and that frame is accepted if it is eligible.
- R6: The field select encoding is as follows. Value 0 keeps frames with `field_i`=0. Value 1 keeps frames with `field_i`=1. Value 2 keeps either field. The reserved value 3 behaves like value 2.
- R7: A frame rejected by the field filter does not advance the decimation counter, so decimation counts eligible frames only.
- R8: During a rejected frame, `out_valid` stays 0, `in_ready` stays 1 and `frame_accept_o` is 0.
- R9: During an accepted frame, `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse, one cycle |
| field_i | input | 1 | Field parity of the frame that is starting |
| decim_code_i | input | 4 | Decimation code |
| field_sel_i | input | 2 | Field parity select |
| in_valid | input | 1 | Input pixel beat valid |
| in_ready | output | 1 | Input beat taken |
| in_data | input | DATA_W | Input pixel data |
| out_valid | output | 1 | Output pixel beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | DATA_W | Output pixel data |
| frame_accept_o | output | 1 | The current frame is being forwarded |

## Verification
The bench targets the following corner cases:
- Code 1 must behave like code 0. A design that read code 1 as "one frame in two" would drop every second frame.
- Code 15 must give a period of sixteen. A counter that wraps one step early or late would accept frame 15 or frame 17 instead of frame 16.
- Field-rejected frames interleaved with decimation expose a counter that advances on every pulse. Such a design would accept the wrong field-0 frames.
- A code change in the middle of a group, and a code change in the middle of a rejected frame, show whether the group restarts and whether the decision leaks into the current frame.
- Back-pressure during rejected frames shows whether discarded beats are still consumed. A design that stalled the source here would hang the capture path.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  typedef enum logic [1:0] {
    FSEL_EVEN = 2'd0,
    FSEL_ODD  = 2'd1,
    FSEL_ANY  = 2'd2,
    FSEL_RSVD = 2'd3
  } fsel_e;

  localparam int unsigned NO_DECIM_MAX = 1;
endpackage

// File: rtl/fdf_field_match.sv
module fdf_field_match
  import fdf_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       field_i,
  output logic       match_o
);
  always_comb begin
    unique case (fsel_e'(sel_i))
      FSEL_EVEN: match_o = !field_i;
      FSEL_ODD:  match_o = field_i;
      default:   match_o = 1'b1;  // either field; reserved code acts the same
    endcase
  end
endmodule

// File: rtl/fdf_decim_ctr.sv
module fdf_decim_ctr
  import fdf_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              eligible_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              keep_o
);
  localparam logic [CODE_W-1:0] NO_DECIM = CODE_W'(NO_DECIM_MAX);

  logic [CODE_W-1:0] cnt_q, code_q, limit, cnt_eff;

  always_comb begin
    limit   = (code_i <= NO_DECIM) ? '0 : code_i;
    cnt_eff = (code_i != code_q) ? '0 : cnt_q;
    keep_o  = eligible_i && (cnt_eff == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (sof_i) begin
      code_q <= code_i;
      if (eligible_i)
        cnt_q <= (cnt_eff >= limit) ? '0 : cnt_eff + 1'b1;
      else
        cnt_q <= cnt_eff;
    end
  end
endmodule

// File: rtl/fdf_stream_gate.sv
module fdf_stream_gate #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              keep_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              accept_o
);
  logic accept_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     accept_q <= 1'b0;
    else if (sof_i) accept_q <= keep_i;
  end

  always_comb begin
    out_valid = in_valid && accept_q;
    out_data  = in_data;
    in_ready  = accept_q ? out_ready : 1'b1;  // dropped beats are swallowed
    accept_o  = accept_q;
  end
endmodule

// File: rtl/frame_decim_filter.sv
module frame_decim_filter #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              field_i,
  input  logic [CODE_W-1:0] decim_code_i,
  input  logic [1:0]        field_sel_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              frame_accept_o
);
  logic eligible, keep;

  fdf_field_match u_match (
    .sel_i   (field_sel_i),
    .field_i (field_i),
    .match_o (eligible)
  );

  fdf_decim_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_i      (sof_i),
    .eligible_i (eligible),
    .code_i     (decim_code_i),
    .keep_o     (keep)
  );

  fdf_stream_gate #(.DATA_W(DATA_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_i     (sof_i),
    .keep_i    (keep),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .accept_o  (frame_accept_o)
  );
endmodule

// File: rtl/frame_decim_filter_chk.sv
module frame_decim_filter_chk #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sof_i,
  input logic              field_i,
  input logic [CODE_W-1:0] decim_code_i,
  input logic [1:0]        field_sel_i,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              frame_accept_o
);
  a_r2_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_i |=> $stable(frame_accept_o));

  a_r3_keep_all: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && decim_code_i < CODE_W'(2) && field_sel_i[1]) |=> frame_accept_o);

  a_r6_wrong_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && ((field_sel_i == 2'd0 && field_i) || (field_sel_i == 2'd1 && !field_i)))
      |=> !frame_accept_o);

  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_accept_o |-> (!out_valid && in_ready));

  a_r9_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept_o |-> (out_valid == in_valid && in_ready == out_ready &&
                        (!out_valid || out_data == in_data)));
endmodule

bind frame_decim_filter frame_decim_filter_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .sof_i          (sof_i),
  .field_i        (field_i),
  .decim_code_i   (decim_code_i),
  .field_sel_i    (field_sel_i),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_data        (in_data),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_data       (out_data),
  .frame_accept_o (frame_accept_o)
);

// File: tb/frame_decim_filter_tb_top.sv
`timescale 1ns/1ps
module frame_decim_filter_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sof_i = 1'b0;
  logic          field_i = 1'b0;
  logic [3:0]    decim_code_i = 4'd0;
  logic [1:0]    field_sel_i = 2'd2;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          frame_accept_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  frame_decim_filter #(.DATA_W(DW), .CODE_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .field_i(field_i),
    .decim_code_i(decim_code_i), .field_sel_i(field_sel_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .frame_accept_o(frame_accept_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Plays n frames; frame k has parity fields[k] and should be kept when exp[k] is 1.
  task automatic play(input string req, input int n, input logic [3:0] code,
                      input logic [1:0] sel, input logic [31:0] fields,
                      input logic [31:0] exp);
    for (int k = 0; k < n; k++) begin
      int got = 0;
      int acc = 0;
      int bad = 0;
      decim_code_i = code;
      field_sel_i  = sel;
      field_i      = fields[k];
      sof_i        = 1'b1;
      @(negedge clk);
      sof_i = 1'b0;
      for (int p = 0; p < 3; p++) begin
        in_valid = 1'b1;
        in_data  = DW'(k * 16 + p);
        #1;
        if (p == 0) acc = int'(frame_accept_o);
        if (out_valid) got++;
        if (out_valid && out_data !== in_data) bad++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      check(req, $sformatf("frame %0d accept", k), acc, int'(exp[k]));
      check(req, $sformatf("frame %0d beats out", k), got, exp[k] ? 3 : 0);
      check("R9", $sformatf("frame %0d data mismatches", k), bad, 0);
    end
  endtask

  task automatic t_reset;  // R1
    in_valid = 1'b1;
    #1;
    check("R1", "accept after reset", int'(frame_accept_o), 0);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_mid_frame_change;  // R2
    play("R2", 1, 4'd2, 2'd2, 32'h0, 32'h1);
    decim_code_i = 4'd2;
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
    decim_code_i = 4'd0;
    field_sel_i  = 2'd2;
    in_valid = 1'b1;
    for (int p = 0; p < 3; p++) begin
      #1;
      check("R2", "mid-frame code change keeps reject", int'(frame_accept_o), 0);
      check("R2", "mid-frame out_valid", int'(out_valid), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    play("R2", 1, 4'd0, 2'd2, 32'h0, 32'h1);
  endtask

  task automatic t_backpressure;  // R8, R9
    play("R9", 1, 4'd0, 2'd2, 32'h0, 32'h1);
    decim_code_i = 4'd0; field_sel_i = 2'd2; field_i = 1'b0; sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0; in_valid = 1'b1; in_data = 16'hA5C3; out_ready = 1'b0;
    #1;
    check("R9", "stalled in_ready", int'(in_ready), 0);
    check("R9", "stalled out_valid", int'(out_valid), 1);
    check("R9", "out_data", int'(out_data), 16'hA5C3);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R9", "released in_ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    field_sel_i = 2'd0; field_i = 1'b1; sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    check("R8", "rejected in_ready under stall", int'(in_ready), 1);
    check("R8", "rejected out_valid", int'(out_valid), 0);
    check("R8", "rejected accept flag", int'(frame_accept_o), 0);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    play("R3", 4, 4'd0, 2'd2, 32'h0, 32'hF);
    play("R3", 3, 4'd1, 2'd2, 32'h0, 32'h7);
    play("R4", 7, 4'd2, 2'd2, 32'h0, 32'h49);
    play("R4", 17, 4'd15, 2'd2, 32'h0, 32'h10001);
    play("R6", 4, 4'd0, 2'd0, 32'hA, 32'h5);
    play("R6", 4, 4'd0, 2'd1, 32'hA, 32'hA);
    play("R6", 4, 4'd0, 2'd3, 32'hA, 32'hF);
    play("R7", 13, 4'd2, 2'd0, 32'h0AAA, 32'h1041);
    play("R5", 2, 4'd3, 2'd2, 32'h0, 32'h1);
    play("R5", 6, 4'd4, 2'd2, 32'h0, 32'h21);
    t_mid_frame_change();
    t_backpressure();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule